// File: doc/BRIEF.md
# OUT Endpoint Receive Buffer Controller

This block looks after the receive storage of one bulk or interrupt OUT endpoint in a USB device controller. The packet engine streams received bytes into an on-chip RAM region whose first location and length are programmed in 64-byte blocks. The CPU empties the region through a read strobe that returns either one byte or a 16-bit little-endian word. Each strobe advances an internal read pointer by the access width.

A two-bit status tells the CPU how many complete units the buffer holds. A unit is one packet in normal mode. In continuous mode a unit is a data set that ends when the half is full or a short packet arrives. Storage can be one region, or two equal halves used in ping-pong order. The CPU releases a unit with a clear strobe. When no free space is left, the block raises a not-ready line so that the packet engine answers NAK and stores nothing.

Top module: `out_ep_rxbuf`

## Requirements
- R1: A read accepted in word mode returns {byte[p+1], byte[p]} and moves the read offset p forward by 2. A read accepted in byte mode returns {8'h00, byte[p]} and moves p forward by 1. Data appears on `cpu_rdata` with `cpu_rvalid` high in the cycle after the strobe.
- R2: Each half starts at `cfg_start_blk`*64 and holds `cfg_size_blk`*64 bytes. A set that fills the half exactly is stored and read back whole. Bytes beyond the half length are dropped.
- R3: With `cfg_dbl`=1, the second half follows the first at `cfg_size_blk`*64, so two units are held at the same time without either corrupting the other.
- R4: With `cfg_dbl`=0, a good end of packet moves `buf_sts` from 00 to 11, and a clear returns it from 11 to 00.
- R5: With `cfg_dbl`=1, each completed unit moves `buf_sts` from 00 to 10, then from 10 to 11.
- R6: With `cfg_dbl`=1, each clear moves `buf_sts` from 11 to 10, then from 10 to 00. Reading after a clear starts at offset 0 of the other half, so units come out in arrival order.
- R7: With `cfg_cont`=1 (bulk endpoints only), status changes only on a good end of packet whose byte count is below `cfg_maxp` (a short packet) or that leaves the half exactly full.
- R8: In continuous mode, consecutive packets of one set are stored back to back. The next set starts at offset 0 of the next half (or of the same region when single).
- R9: An end of packet with `pe_good`=0 restores the write offset to where that packet began and leaves the status unchanged.
- R10: `pe_nak` is 1 exactly while no free unit remains. While it is 1, the block ignores data bytes and ends of packet.
- R11: A read strobe while `buf_sts[1]`=0 is ignored: no `cpu_rvalid` and no pointer movement.
- R12: After reset, `buf_sts`=00, `pe_nak`=0 and `cpu_rvalid`=0.
- R13: A clear while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_blk | input | START_W | Region start, in 64-byte blocks |
| cfg_size_blk | input | SIZE_W | Half length in 64-byte blocks (1..MAX_BLKS) |
| cfg_dbl | input | 1 | 1 = two ping-pong halves |
| cfg_cont | input | 1 | 1 = continuous (per data set) status |
| cfg_maxp | input | MAXP_W | Maximum packet size in bytes |
| pe_wr_en | input | 1 | Received data byte valid (never together with pe_eop) |
| pe_wr_data | input | 8 | Received data byte |
| pe_eop | input | 1 | End of packet strobe |
| pe_good | input | 1 | Packet passed its checks (qualifies pe_eop) |
| pe_nak | output | 1 | No free space; packet engine must NAK |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_clr | input | 1 | CPU releases the oldest unit |
| cpu_rdata | output | 16 | Read data |
| cpu_rvalid | output | 1 | cpu_rdata valid |
| buf_sts | output | 2 | Held units: 00 none, 10 one of two, 11 full |

## Verification
The hardest state to reach is a continuous-mode set that spans several packets. The write pointer has to carry across ends of packet with no status change. The set then has to close on exactly the half boundary while the other half still holds an unread short set. The stimulus first sends two full-size packets and a short one, and reads all forty bytes across the packet seams. It then sends four full-size packets into the second half and checks that only the fourth one raises the status. Finally it drains both halves and confirms that a new set lands back at the first offset.

// File: rtl/out_ep_rxbuf_pkg.sv
package out_ep_rxbuf_pkg;

  localparam int unsigned BLK_SHIFT = 6;

  typedef enum logic [1:0] {
    RXB_EMPTY = 2'b00,
    RXB_ONE   = 2'b10,
    RXB_FULL  = 2'b11
  } rxb_sts_e;

  // map held-unit count to the status code
  function automatic rxb_sts_e sts_of(input logic [1:0] held, input logic dbl);
    if (held == 2'd0) return RXB_EMPTY;
    if (!dbl || held >= 2'd2) return RXB_FULL;
    return RXB_ONE;
  endfunction

endpackage

// File: rtl/rxb_ram.sv
module rxb_ram #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [15:0]       q_pair
);
  localparam int unsigned DEPTH = 1 << (ADDR_W - 1);

  logic [ADDR_W-2:0] widx;
  assign widx = waddr[ADDR_W-1:1];

  // bank 0 holds even byte addresses, bank 1 odd ones
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0]        mem [DEPTH];
    logic [7:0]        q_r;
    logic [ADDR_W-2:0] ridx;

    if (g == 0) begin : g_even
      assign ridx = raddr[ADDR_W-1:1] + (ADDR_W-1)'(raddr[0]);
    end else begin : g_odd
      assign ridx = raddr[ADDR_W-1:1];
    end

    always_ff @(posedge clk) begin
      if (we && (waddr[0] == 1'(g))) mem[widx] <= wdata;
      if (re) q_r <= mem[ridx];
    end

    assign q_pair[8*g +: 8] = q_r;
  end

endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import out_ep_rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dbl,
  input  logic       unit_done,
  input  logic       clr,
  output logic [1:0] sts,
  output logic       nak,
  output logic       clr_ok
);
  logic [1:0] held_q, held_d, cap;

  always_comb begin
    cap    = dbl ? 2'd2 : 2'd1;
    clr_ok = clr && (held_q != 2'd0);
    held_d = held_q + {1'b0, unit_done} - {1'b0, clr_ok};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 2'd0;
      sts    <= RXB_EMPTY;
      nak    <= 1'b0;
    end else begin
      held_q <= held_d;
      sts    <= sts_of(held_d, dbl);
      nak    <= (held_d >= cap);
    end
  end

  p_held_cap_r10: assert property (@(posedge clk) disable iff (rst)
    held_q <= cap);
  p_single_code_r4: assert property (@(posedge clk) disable iff (rst)
    !dbl |-> (sts == 2'b00 || sts == 2'b11));
  p_fill_step_r5: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !clr) |=> (held_q == $past(held_q) + 2'd1));
  p_clear_step_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_ok && !unit_done) |=> (held_q == $past(held_q) - 2'd1));
  p_empty_clear_r13: assert property (@(posedge clk) disable iff (rst)
    (clr && held_q == 2'd0 && !unit_done) |=> (sts == 2'b00));

endmodule

// File: rtl/rxb_wr_ctrl.sv
module rxb_wr_ctrl
  import out_ep_rxbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned START_W = 5,
  parameter int unsigned SIZE_W  = 5,
  parameter int unsigned OFF_W   = 11,
  parameter int unsigned MAXP_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [START_W-1:0] cfg_start_blk,
  input  logic [SIZE_W-1:0]  cfg_size_blk,
  input  logic               cfg_dbl,
  input  logic               cfg_cont,
  input  logic [MAXP_W-1:0]  cfg_maxp,
  input  logic               pe_wr_en,
  input  logic [7:0]         pe_wr_data,
  input  logic               pe_eop,
  input  logic               pe_good,
  input  logic               nak,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_waddr,
  output logic [7:0]         ram_wdata,
  output logic               unit_done
);
  localparam int unsigned CW  = (OFF_W > MAXP_W) ? OFF_W : MAXP_W;
  localparam int unsigned AW2 = ADDR_W + 2;

  logic              wr_half;
  logic [OFF_W-1:0]  wr_off, pkt_start, pkt_cnt, half_bytes;
  logic [ADDR_W-1:0] region, base;
  logic              offered, eop_ok, good_end, is_short, set_full;

  always_comb begin
    half_bytes = OFF_W'(cfg_size_blk) << BLK_SHIFT;
    region     = ADDR_W'(cfg_start_blk) << BLK_SHIFT;
    base       = region + (wr_half ? ADDR_W'(half_bytes) : '0);
    offered    = pe_wr_en && !pe_eop && !nak;
    ram_we     = offered && (wr_off < half_bytes);
    ram_waddr  = base + ADDR_W'(wr_off);
    ram_wdata  = pe_wr_data;
    eop_ok     = pe_eop && !nak;
    good_end   = eop_ok && pe_good;
    is_short   = CW'(pkt_cnt) < CW'(cfg_maxp);
    set_full   = (wr_off == half_bytes);
    unit_done  = good_end && (!cfg_cont || is_short || set_full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_half   <= 1'b0;
      wr_off    <= '0;
      pkt_start <= '0;
      pkt_cnt   <= '0;
    end else if (eop_ok) begin
      pkt_cnt <= '0;
      if (!pe_good) begin
        wr_off <= pkt_start;
      end else if (unit_done) begin
        wr_off    <= '0;
        pkt_start <= '0;
        if (cfg_dbl) wr_half <= ~wr_half;
      end else begin
        pkt_start <= wr_off;
      end
    end else if (offered) begin
      pkt_cnt <= pkt_cnt + 1'b1;
      if (ram_we) wr_off <= wr_off + 1'b1;
    end
  end

  p_wr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ((AW2'(ram_waddr) >= AW2'(region)) &&
                (AW2'(ram_waddr) < AW2'(region) + (AW2'(half_bytes) << cfg_dbl))));
  p_no_write_nak_r10: assert property (@(posedge clk) disable iff (rst)
    nak |-> !ram_we);
  p_rollback_r9: assert property (@(posedge clk) disable iff (rst)
    (eop_ok && !pe_good) |=> (wr_off == $past(pkt_start)));
  p_accum_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_cont && good_end && !unit_done) |=> (wr_off == $past(wr_off)));

endmodule

// File: rtl/rxb_rd_ctrl.sv
module rxb_rd_ctrl
  import out_ep_rxbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned START_W = 5,
  parameter int unsigned SIZE_W  = 5,
  parameter int unsigned OFF_W   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [START_W-1:0] cfg_start_blk,
  input  logic [SIZE_W-1:0]  cfg_size_blk,
  input  logic               cfg_dbl,
  input  logic               cpu_rd,
  input  logic               cpu_word,
  input  logic               cpu_clr,
  input  logic               clr_ok,
  input  logic               sts_hi,
  output logic               ram_re,
  output logic [ADDR_W-1:0]  ram_raddr,
  output logic               rvalid,
  output logic               rword,
  output logic               rodd
);
  logic             rd_half;
  logic [OFF_W-1:0] rd_off, half_bytes;

  always_comb begin
    half_bytes = OFF_W'(cfg_size_blk) << BLK_SHIFT;
    ram_re     = cpu_rd && sts_hi;
    ram_raddr  = (ADDR_W'(cfg_start_blk) << BLK_SHIFT)
               + (rd_half ? ADDR_W'(half_bytes) : '0)
               + ADDR_W'(rd_off);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_half <= 1'b0;
      rd_off  <= '0;
      rvalid  <= 1'b0;
      rword   <= 1'b0;
      rodd    <= 1'b0;
    end else begin
      rvalid <= ram_re;
      if (ram_re) begin
        rword <= cpu_word;
        rodd  <= ram_raddr[0];
      end
      if (clr_ok) begin
        rd_off <= '0;
        if (cfg_dbl) rd_half <= ~rd_half;
      end else if (ram_re) begin
        rd_off <= rd_off + (cpu_word ? OFF_W'(2) : OFF_W'(1));
      end
    end
  end

  p_rd_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!sts_hi && !cpu_clr) |=> $stable(rd_off));
  p_word_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && sts_hi && cpu_word && !cpu_clr) |=> (rd_off == $past(rd_off) + OFF_W'(2)));
  p_byte_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && sts_hi && !cpu_word && !cpu_clr) |=> (rd_off == $past(rd_off) + OFF_W'(1)));
  p_clear_rewind_r6: assert property (@(posedge clk) disable iff (rst)
    clr_ok |=> (rd_off == '0));

endmodule

// File: rtl/out_ep_rxbuf.sv
module out_ep_rxbuf
  import out_ep_rxbuf_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 2048,
  parameter int unsigned MAX_BLKS  = 16,
  parameter int unsigned MAXP_W    = 11,
  localparam int unsigned ADDR_W   = $clog2(RAM_BYTES),
  localparam int unsigned START_W  = ADDR_W - BLK_SHIFT,
  localparam int unsigned SIZE_W   = $clog2(MAX_BLKS + 1),
  localparam int unsigned OFF_W    = $clog2((MAX_BLKS << BLK_SHIFT) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [START_W-1:0] cfg_start_blk,
  input  logic [SIZE_W-1:0]  cfg_size_blk,
  input  logic               cfg_dbl,
  input  logic               cfg_cont,
  input  logic [MAXP_W-1:0]  cfg_maxp,
  input  logic               pe_wr_en,
  input  logic [7:0]         pe_wr_data,
  input  logic               pe_eop,
  input  logic               pe_good,
  output logic               pe_nak,
  input  logic               cpu_rd,
  input  logic               cpu_word,
  input  logic               cpu_clr,
  output logic [15:0]        cpu_rdata,
  output logic               cpu_rvalid,
  output logic [1:0]         buf_sts
);
  logic              ram_we, ram_re, unit_done, clr_ok, rword, rodd;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [7:0]        ram_wdata, lo_b, hi_b;
  logic [15:0]       q_pair;

  rxb_status u_status (
    .clk(clk), .rst(rst), .dbl(cfg_dbl), .unit_done(unit_done), .clr(cpu_clr),
    .sts(buf_sts), .nak(pe_nak), .clr_ok(clr_ok)
  );

  rxb_wr_ctrl #(
    .ADDR_W(ADDR_W), .START_W(START_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .MAXP_W(MAXP_W)
  ) u_wr (
    .clk(clk), .rst(rst), .cfg_start_blk(cfg_start_blk), .cfg_size_blk(cfg_size_blk),
    .cfg_dbl(cfg_dbl), .cfg_cont(cfg_cont), .cfg_maxp(cfg_maxp),
    .pe_wr_en(pe_wr_en), .pe_wr_data(pe_wr_data), .pe_eop(pe_eop), .pe_good(pe_good),
    .nak(pe_nak), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .unit_done(unit_done)
  );

  rxb_rd_ctrl #(
    .ADDR_W(ADDR_W), .START_W(START_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)
  ) u_rd (
    .clk(clk), .rst(rst), .cfg_start_blk(cfg_start_blk), .cfg_size_blk(cfg_size_blk),
    .cfg_dbl(cfg_dbl), .cpu_rd(cpu_rd), .cpu_word(cpu_word), .cpu_clr(cpu_clr),
    .clr_ok(clr_ok), .sts_hi(buf_sts[1]), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .rvalid(cpu_rvalid), .rword(rword), .rodd(rodd)
  );

  rxb_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .q_pair(q_pair)
  );

  // pick byte lanes after the registered bank outputs
  always_comb begin
    lo_b      = rodd ? q_pair[15:8] : q_pair[7:0];
    hi_b      = rodd ? q_pair[7:0]  : q_pair[15:8];
    cpu_rdata = rword ? {hi_b, lo_b} : {8'h00, lo_b};
  end

  p_valid_gate_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(buf_sts[1]));
  p_nak_full_r10: assert property (@(posedge clk) disable iff (rst)
    (buf_sts == 2'b11) |-> pe_nak);

endmodule

// File: tb/out_ep_rxbuf_test.sv
`timescale 1ns/1ps
module out_ep_rxbuf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_start_blk = 5'd2;
  logic [4:0]  cfg_size_blk  = 5'd1;
  logic        cfg_dbl = 1'b0, cfg_cont = 1'b0;
  logic [10:0] cfg_maxp = 11'd16;
  logic        pe_wr_en = 1'b0, pe_eop = 1'b0, pe_good = 1'b0;
  logic [7:0]  pe_wr_data = 8'h00;
  logic        pe_nak;
  logic        cpu_rd = 1'b0, cpu_word = 1'b0, cpu_clr = 1'b0;
  logic [15:0] cpu_rdata;
  logic        cpu_rvalid;
  logic [1:0]  buf_sts;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  out_ep_rxbuf uut (
    .clk(clk), .rst(rst), .cfg_start_blk(cfg_start_blk), .cfg_size_blk(cfg_size_blk),
    .cfg_dbl(cfg_dbl), .cfg_cont(cfg_cont), .cfg_maxp(cfg_maxp),
    .pe_wr_en(pe_wr_en), .pe_wr_data(pe_wr_data), .pe_eop(pe_eop), .pe_good(pe_good),
    .pe_nak(pe_nak), .cpu_rd(cpu_rd), .cpu_word(cpu_word), .cpu_clr(cpu_clr),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .buf_sts(buf_sts)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare every returned read
  always @(negedge clk) begin
    if (!rst && cpu_rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 16'd1, 16'd0);
      else chk(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
    end
  end

  task automatic send_pkt(input int n, input logic [7:0] seed, input logic good);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pe_wr_en = 1'b1; pe_wr_data = 8'(seed + 8'(i));
    end
    @(negedge clk); pe_wr_en = 1'b0; pe_eop = 1'b1; pe_good = good;
    @(negedge clk); pe_eop = 1'b0; pe_good = 1'b0;
  endtask

  task automatic rd(input logic word, input logic [15:0] exp, input string tag);
    @(negedge clk); cpu_rd = 1'b1; cpu_word = word;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); cpu_clr = 1'b1;
    @(negedge clk); cpu_clr = 1'b0;
  endtask

  function automatic logic [7:0] set_byte(input int k);
    if (k < 16) return 8'(8'h60 + k);
    if (k < 32) return 8'(8'h70 + k - 16);
    return 8'(8'h90 + k - 32);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 sts", 16'(buf_sts), 16'h0);
    chk("R12 nak", 16'(pe_nak), 16'h0);
    chk("R12 rvalid", 16'(cpu_rvalid), 16'h0);

    // reads and clears while empty
    @(negedge clk); cpu_rd = 1'b1; cpu_word = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    chk("R11 rvalid while empty", 16'(cpu_rvalid), 16'h0);
    clr();
    chk("R13 clear while empty", 16'(buf_sts), 16'h0);

    // single buffer, per packet
    send_pkt(8, 8'h10, 1'b1);
    chk("R4 sts after packet", 16'(buf_sts), 16'h3);
    chk("R10 nak when full", 16'(pe_nak), 16'h1);
    send_pkt(4, 8'h80, 1'b1);
    chk("R10 packet during nak", 16'(buf_sts), 16'h3);
    rd(1'b0, 16'h0010, "R1 byte read");
    rd(1'b1, 16'h1211, "R1 word read at odd offset");
    rd(1'b0, 16'h0013, "R1 byte after word");
    rd(1'b1, 16'h1514, "R10 data kept during nak");
    clr();
    chk("R4 sts after clear", 16'(buf_sts), 16'h0);
    chk("R10 nak released", 16'(pe_nak), 16'h0);

    // bad packet rolls back
    send_pkt(6, 8'h40, 1'b0);
    chk("R9 sts after bad packet", 16'(buf_sts), 16'h0);
    send_pkt(4, 8'h50, 1'b1);
    chk("R9 sts after good packet", 16'(buf_sts), 16'h3);
    rd(1'b1, 16'h5150, "R9 overwrite from start");
    rd(1'b1, 16'h5352, "R9 second word");
    clr();

    // double buffer, per packet
    cfg_dbl = 1'b1;
    send_pkt(4, 8'h20, 1'b1);
    chk("R5 one held", 16'(buf_sts), 16'h2);
    chk("R10 nak with one free", 16'(pe_nak), 16'h0);
    send_pkt(4, 8'h30, 1'b1);
    chk("R5 two held", 16'(buf_sts), 16'h3);
    chk("R10 nak with both held", 16'(pe_nak), 16'h1);
    rd(1'b1, 16'h2120, "R6 first unit first");
    clr();
    chk("R6 sts after first clear", 16'(buf_sts), 16'h2);
    rd(1'b1, 16'h3130, "R3 second half intact");
    clr();
    chk("R6 sts after second clear", 16'(buf_sts), 16'h0);

    // continuous mode, double buffer
    cfg_cont = 1'b1;
    send_pkt(16, 8'h60, 1'b1);
    chk("R7 no update mid set", 16'(buf_sts), 16'h0);
    send_pkt(16, 8'h70, 1'b1);
    chk("R7 no update mid set 2", 16'(buf_sts), 16'h0);
    send_pkt(8, 8'h90, 1'b1);
    chk("R7 short packet ends set", 16'(buf_sts), 16'h2);
    for (int w = 0; w < 20; w++)
      rd(1'b1, {set_byte(2*w+1), set_byte(2*w)}, "R8 packets back to back");
    for (int j = 0; j < 4; j++) begin
      send_pkt(16, 8'(8'hC0 + 16*j), 1'b1);
      if (j < 3) chk("R7 partial set no update", 16'(buf_sts), 16'h2);
    end
    chk("R7 full set ends set", 16'(buf_sts), 16'h3);
    clr();
    chk("R6 sts after clear in cont", 16'(buf_sts), 16'h2);
    for (int w = 0; w < 32; w++)
      rd(1'b1, {8'(8'hC0 + 2*w + 1), 8'(8'hC0 + 2*w)}, "R2 full half read");
    clr();
    chk("R6 empty after cont drain", 16'(buf_sts), 16'h0);
    send_pkt(4, 8'h11, 1'b1);
    chk("R7 short set", 16'(buf_sts), 16'h2);
    rd(1'b1, 16'h1211, "R8 new set at offset 0");
    clr();

    repeat (3) @(negedge clk);
    chk("R1 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule